// File: doc/BRIEF.md
# Sector Buffer Fill/Empty DMA Engine

This block moves bytes between a local 256-byte sector buffer and host memory through a byte-wide request port with a valid/ready handshake. A fill loads the buffer from memory. An empty copies the buffer out to memory. A third operation writes an 8-byte status record, supplied on an input bus, to memory through the same port. The memory address is 18 bits wide: a 2-bit extension above a 16-bit bus address.

A controller pulses `startPulse` with the operation, the word count, the address and the density. The block first checks the word count against the sector size for the selected density. For a fill, it then clears the buffer. After that it issues one memory beat per byte, in ascending address order. It ends with a one-cycle `donePulse`. The overflow flag, the non-existent-memory flag, the error code and the residual word count all hold until the next accepted start. The buffer can be read at any time through an index/data pair.

Top module: `dma_sector_xfer`

## Requirements
- R1: After reset, `memReqValid`, `donePulse`, `wcOverflow` and `nxmFlag` are 0, `errCode` and `residualWc` are 0, and every buffer byte reads 0.
- R2: A fill or empty of word count N moves exactly 2*N bytes, one per accepted beat. The first address is `addrExt` shifted left by 16 and ORed with `busAddr`, and each later beat uses the previous address plus one.
- R3: For a fill or empty, if 2*N exceeds the sector size (128 bytes when `dblDensity`=0, 256 bytes when 1), no request is issued. The operation finishes with `wcOverflow`=1 and `errCode`=8'o230 (0x98), and the buffer is left untouched. Exactly 128 or 256 bytes is accepted.
- R4: A fill (`opSel`=0) sets all 256 buffer bytes to zero before any beat. Byte k returned by memory is then stored at buffer index k, and indexes that are not reached stay zero.
- R5: An empty (`opSel`=1) issues write beats (`memReqWrite`=1) whose data is buffer byte k on beat k.
- R6: A status write (`opSel`=2 or 3) issues exactly 8 write beats. Beat k carries `statusBytes[8k+7:8k]`. The word count and density have no effect on it, and it never sets `wcOverflow`.
- R7: When an accepted beat returns `memRspErr`, that beat's data is not stored and no further beat is issued. The operation finishes with `nxmFlag`=1. For a fill or empty, `residualWc` becomes the number of bytes not moved (the faulted beat included) divided by two, rounded down.
- R8: A fill or empty with word count 0 finishes with no memory request. A fill with word count 0 still clears the buffer.
- R9: While `memReqValid` is 1 and `memReqReady` is 0, the request (valid, address, direction, write data) holds unchanged on the next cycle.
- R10: `donePulse` lasts exactly one cycle. A start seen while an operation is in progress is ignored. `residualWc` takes the word count at start, and becomes 0 when a fill or empty completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin an operation (taken only when idle) |
| opSel | input | 2 | 0 fill, 1 empty, 2 or 3 status write |
| wordCount | input | 8 | Words to move (bytes = 2 x words) |
| addrExt | input | 2 | Upper two address bits |
| busAddr | input | 16 | Lower sixteen address bits |
| dblDensity | input | 1 | 1 selects 256-byte sectors, 0 selects 128-byte sectors |
| statusBytes | input | 64 | Status record, byte k in bits 8k+7:8k |
| memReqValid | output | 1 | Memory beat requested |
| memReqReady | input | 1 | Memory accepts the beat this cycle |
| memReqWrite | output | 1 | 1 write to memory, 0 read from memory |
| memReqAddr | output | 18 | Byte address of the beat |
| memWData | output | 8 | Write data of the beat |
| memRData | input | 8 | Read data, valid with the accepting cycle |
| memRspErr | input | 1 | Accepted beat faulted |
| bufRdIdx | input | 8 | Buffer read index |
| bufRdData | output | 8 | Buffer byte at `bufRdIdx` |
| donePulse | output | 1 | One-cycle completion strobe |
| wcOverflow | output | 1 | Word count exceeded the sector size |
| nxmFlag | output | 1 | A memory beat faulted |
| errCode | output | 8 | 0x98 on overflow, 0 otherwise |
| residualWc | output | 8 | Residual word count |

## Verification
A corrupted remaining-byte count shows up at the ports within one beat. The done pulse arrives early or late relative to the reference, or the residual word count after a fault differs. A wrong address or index register shows on the next request as a mismatched address or write data. A missing or partial clear appears only when the buffer is read back after a short fill, so every fill is followed by a sweep of all 256 indexes. A state machine that skips its check step would issue a request in a cycle where the reference issues none; this is compared on every clock.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [1:0] {
    OP_FILL     = 2'd0,
    OP_EMPTY    = 2'd1,
    OP_STAT     = 2'd2,
    OP_STAT_ALT = 2'd3
  } xferOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch address and status record
    logic clearAll;   // zero the whole buffer
    logic stepBeat;   // a beat was accepted without fault
    logic storeByte;  // write read data into the buffer
    logic useStatus;  // write data comes from the status record
  } dpStrobe_t;

  localparam logic [7:0] WCO_CODE = 8'o230;

endpackage

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
  import dma_xfer_pkg::*;
#(
  parameter int BUF_BYTES  = 256,
  parameter int WC_W       = 8,
  parameter int STAT_BYTES = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startPulse,
  input  logic [1:0]      opSel,
  input  logic [WC_W-1:0] wordCount,
  input  logic            dblDensity,
  input  logic            memReqReady,
  input  logic            memRspErr,
  output dpStrobe_t       strb,
  output logic            memReqValid,
  output logic            memReqWrite,
  output logic            donePulse,
  output logic            wcOverflow,
  output logic            nxmFlag,
  output logic [7:0]      errCode,
  output logic [WC_W-1:0] residualWc
);

  localparam int CNT_W = WC_W + 2;
  localparam logic [CNT_W-1:0] SEC_DBL = CNT_W'(BUF_BYTES);
  localparam logic [CNT_W-1:0] SEC_SGL = CNT_W'(BUF_BYTES / 2);
  localparam logic [CNT_W-1:0] STAT_CNT = CNT_W'(STAT_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_CLEAR, ST_MOVE, ST_FINISH
  } ctrlState_t;

  ctrlState_t      state;
  xferOp_t         opReg;
  logic [WC_W-1:0] wcReg;
  logic            dblReg;
  logic [CNT_W-1:0] remBytes;
  logic            wcoR;
  logic            nxmR;
  logic [WC_W-1:0] resR;

  logic [CNT_W-1:0] byteReq;
  logic [CNT_W-1:0] secBytes;
  logic             tooBig;
  logic             isStatus;
  logic             accept;

  assign byteReq  = {1'b0, wcReg, 1'b0};
  assign secBytes = dblReg ? SEC_DBL : SEC_SGL;
  assign isStatus = opReg[1];
  assign tooBig   = !isStatus && (byteReq > secBytes);
  assign accept   = (state == ST_MOVE) && memReqReady;

  assign memReqValid = (state == ST_MOVE);
  assign memReqWrite = (opReg != OP_FILL);
  assign donePulse   = (state == ST_FINISH);
  assign wcOverflow  = wcoR;
  assign nxmFlag     = nxmR;
  assign errCode     = wcoR ? WCO_CODE : 8'd0;
  assign residualWc  = resR;

  always_comb begin
    strb           = '0;
    strb.capture   = (state == ST_IDLE) && startPulse;
    strb.clearAll  = (state == ST_CLEAR);
    strb.stepBeat  = accept && !memRspErr;
    strb.storeByte = accept && !memRspErr && (opReg == OP_FILL);
    strb.useStatus = isStatus;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      opReg    <= OP_FILL;
      wcReg    <= '0;
      dblReg   <= 1'b0;
      remBytes <= '0;
      wcoR     <= 1'b0;
      nxmR     <= 1'b0;
      resR     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startPulse) begin
            opReg    <= xferOp_t'(opSel);
            wcReg    <= wordCount;
            dblReg   <= dblDensity;
            wcoR     <= 1'b0;
            nxmR     <= 1'b0;
            resR     <= wordCount;
            remBytes <= opSel[1] ? STAT_CNT : {1'b0, wordCount, 1'b0};
            state    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (tooBig) begin
            wcoR  <= 1'b1;
            state <= ST_FINISH;
          end else if (opReg == OP_FILL) begin
            state <= ST_CLEAR;
          end else begin
            state <= (remBytes == '0) ? ST_FINISH : ST_MOVE;
          end
        end
        ST_CLEAR: begin
          state <= (remBytes == '0) ? ST_FINISH : ST_MOVE;
        end
        ST_MOVE: begin
          if (accept) begin
            if (memRspErr) begin
              nxmR <= 1'b1;
              if (!isStatus) resR <= WC_W'(remBytes >> 1);
              state <= ST_FINISH;
            end else begin
              remBytes <= remBytes - 1'b1;
              if (remBytes == CNT_W'(1)) begin
                if (!isStatus) resR <= '0;
                state <= ST_FINISH;
              end
            end
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R3
  no_traffic_on_wco_chk: assert property (@(posedge clk) disable iff (!rstN)
    wcOverflow |-> !memReqValid);

  // R7
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wcOverflow && nxmFlag));

  // R7
  stop_after_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqReady && memRspErr) |=> (!memReqValid && donePulse));

endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath
  import dma_xfer_pkg::*;
#(
  parameter int BUF_BYTES  = 256,
  parameter int EXT_W      = 2,
  parameter int BA_W       = 16,
  parameter int STAT_BYTES = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 strb,
  input  logic [EXT_W-1:0]          addrExt,
  input  logic [BA_W-1:0]           busAddr,
  input  logic [STAT_BYTES*8-1:0]   statusBytes,
  input  logic [7:0]                memRData,
  input  logic [$clog2(BUF_BYTES)-1:0] bufRdIdx,
  output logic [EXT_W+BA_W-1:0]     memReqAddr,
  output logic [7:0]                memWData,
  output logic [7:0]                bufRdData
);

  localparam int ADDR_W = EXT_W + BA_W;
  localparam int IDX_W  = $clog2(BUF_BYTES);
  localparam int SIDX_W = $clog2(STAT_BYTES);

  logic [ADDR_W-1:0]         addrReg;
  logic [IDX_W-1:0]          idxReg;
  logic [STAT_BYTES*8-1:0]   statReg;
  logic [7:0]                bufMem [BUF_BYTES];
  logic [SIDX_W-1:0]         statIdx;

  assign statIdx    = idxReg[SIDX_W-1:0];
  assign memReqAddr = addrReg;
  assign bufRdData  = bufMem[bufRdIdx];
  assign memWData   = strb.useStatus ? statReg[8*int'(statIdx) +: 8] : bufMem[idxReg];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      idxReg  <= '0;
      statReg <= '0;
    end else if (strb.capture) begin
      addrReg <= {addrExt, busAddr};
      idxReg  <= '0;
      statReg <= statusBytes;
    end else if (strb.stepBeat) begin
      addrReg <= addrReg + 1'b1;
      idxReg  <= idxReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      for (int i = 0; i < BUF_BYTES; i++) bufMem[i] <= 8'd0;
    end else if (strb.storeByte) begin
      bufMem[idxReg] <= memRData;
    end
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.stepBeat |=> (memReqAddr == $past(memReqAddr) + 1'b1));

  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (memReqAddr == {$past(addrExt), $past(busAddr)}));

endmodule

// File: rtl/dma_sector_xfer.sv
module dma_sector_xfer
  import dma_xfer_pkg::*;
#(
  parameter int BUF_BYTES  = 256,
  parameter int WC_W       = 8,
  parameter int EXT_W      = 2,
  parameter int BA_W       = 16,
  parameter int STAT_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startPulse,
  input  logic [1:0]             opSel,
  input  logic [WC_W-1:0]        wordCount,
  input  logic [EXT_W-1:0]       addrExt,
  input  logic [BA_W-1:0]        busAddr,
  input  logic                   dblDensity,
  input  logic [STAT_BYTES*8-1:0] statusBytes,
  output logic                   memReqValid,
  input  logic                   memReqReady,
  output logic                   memReqWrite,
  output logic [EXT_W+BA_W-1:0]  memReqAddr,
  output logic [7:0]             memWData,
  input  logic [7:0]             memRData,
  input  logic                   memRspErr,
  input  logic [$clog2(BUF_BYTES)-1:0] bufRdIdx,
  output logic [7:0]             bufRdData,
  output logic                   donePulse,
  output logic                   wcOverflow,
  output logic                   nxmFlag,
  output logic [7:0]             errCode,
  output logic [WC_W-1:0]        residualWc
);

  dpStrobe_t strb;

  xfer_ctrl #(
    .BUF_BYTES(BUF_BYTES), .WC_W(WC_W), .STAT_BYTES(STAT_BYTES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opSel(opSel),
    .wordCount(wordCount), .dblDensity(dblDensity),
    .memReqReady(memReqReady), .memRspErr(memRspErr), .strb(strb),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .donePulse(donePulse), .wcOverflow(wcOverflow), .nxmFlag(nxmFlag),
    .errCode(errCode), .residualWc(residualWc)
  );

  xfer_datapath #(
    .BUF_BYTES(BUF_BYTES), .EXT_W(EXT_W), .BA_W(BA_W), .STAT_BYTES(STAT_BYTES)
  ) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .addrExt(addrExt), .busAddr(busAddr),
    .statusBytes(statusBytes), .memRData(memRData), .bufRdIdx(bufRdIdx),
    .memReqAddr(memReqAddr), .memWData(memWData), .bufRdData(bufRdData)
  );

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memWData) && $stable(memReqWrite)));

endmodule

// File: tb/sim_dma_sector_xfer.sv
module sim_dma_sector_xfer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [7:0]  wordCount = 8'd0;
  logic [1:0]  addrExt = 2'd0;
  logic [15:0] busAddr = 16'd0;
  logic        dblDensity = 1'b0;
  logic [63:0] statusBytes = 64'h0;
  logic        memReqValid, memReqWrite;
  logic        memReqReady = 1'b0;
  logic [17:0] memReqAddr;
  logic [7:0]  memWData, memRData;
  logic        memRspErr;
  logic [7:0]  bufRdIdx = 8'd0;
  logic [7:0]  bufRdData;
  logic        donePulse, wcOverflow, nxmFlag;
  logic [7:0]  errCode, residualWc;

  bit          faultOn = 1'b0;
  logic [17:0] faultAddr = '0;

  int cmpCnt = 0, failCnt = 0, cyc = 0;
  int beatCnt = 0, validCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] patByte(logic [17:0] a);
    return 8'(a * 37 + 11) ^ 8'(a >> 9);
  endfunction

  assign memRData  = patByte(memReqAddr);
  assign memRspErr = faultOn && memReqValid && (memReqAddr == faultAddr);

  dma_sector_xfer u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .opSel(opSel),
    .wordCount(wordCount), .addrExt(addrExt), .busAddr(busAddr),
    .dblDensity(dblDensity), .statusBytes(statusBytes),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memWData(memWData),
    .memRData(memRData), .memRspErr(memRspErr), .bufRdIdx(bufRdIdx),
    .bufRdData(bufRdData), .donePulse(donePulse), .wcOverflow(wcOverflow),
    .nxmFlag(nxmFlag), .errCode(errCode), .residualWc(residualWc)
  );

  task automatic chk(string tag, int act, int exp);
    cmpCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  int          mPh = 0;      // 0 idle, 1 check, 2 clear, 3 move, 4 finish
  int          mOp = 0;
  int          mWc = 0;
  int          mRem = 0;
  int          mIdx = 0;
  bit          mDbl = 0;
  logic [17:0] mAddr = '0;
  logic [63:0] mStat = '0;
  bit          mWco = 0, mNxm = 0;
  int          mRes = 0;
  logic [7:0]  mBuf [256];

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mWco = 0; mNxm = 0; mRes = 0; mAddr = '0;
      foreach (mBuf[i]) mBuf[i] = 8'd0;
    end else begin
      if (memReqValid && memReqReady) beatCnt++;
      if (memReqValid) validCnt++;
      case (mPh)
        0: if (startPulse) begin
             mOp = opSel; mWc = wordCount; mDbl = dblDensity;
             mAddr = {addrExt, busAddr}; mStat = statusBytes; mIdx = 0;
             mWco = 0; mNxm = 0; mRes = wordCount;
             mRem = (opSel >= 2) ? 8 : 2 * wordCount;
             mPh = 1;
           end
        1: begin
             if (mOp < 2 && 2 * mWc > (mDbl ? 256 : 128)) begin mWco = 1; mPh = 4; end
             else if (mOp == 0) mPh = 2;
             else mPh = (mRem == 0) ? 4 : 3;
           end
        2: begin
             foreach (mBuf[i]) mBuf[i] = 8'd0;
             mPh = (mRem == 0) ? 4 : 3;
           end
        3: if (memReqReady) begin
             if (faultOn && mAddr == faultAddr) begin
               mNxm = 1;
               if (mOp < 2) mRes = mRem / 2;
               mPh = 4;
             end else begin
               if (mOp == 0) mBuf[mIdx] = patByte(mAddr);
               mIdx++; mAddr = mAddr + 18'd1; mRem--;
               if (mRem == 0) begin if (mOp < 2) mRes = 0; mPh = 4; end
             end
           end
        default: mPh = 0;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 memReqValid", memReqValid, mPh == 3);
      if (mPh == 3) begin
        chk("R2/R9 memReqAddr", memReqAddr, mAddr);
        chk("R5 memReqWrite", memReqWrite, mOp != 0);
        if (mOp == 1) chk("R5 memWData", memWData, mBuf[mIdx]);
        if (mOp >= 2) chk("R6 memWData", memWData, mStat[8*mIdx +: 8]);
      end
      chk("R10 donePulse", donePulse, mPh == 4);
      chk("R3 wcOverflow", wcOverflow, mWco);
      chk("R3 errCode", errCode, mWco ? 8'h98 : 8'h00);
      chk("R7 nxmFlag", nxmFlag, mNxm);
      chk("R7 residualWc", residualWc, mRes);
    end
  end

  // ready pattern with stalls
  always @(negedge clk) begin
    cyc++;
    memReqReady = ((cyc % 5) != 3) && ((cyc % 7) != 0);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      failCnt++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, failCnt);
      $finish;
    end
  end

  task automatic runOp(int op, int wc, int ext, int ba, bit dbl, bit poke);
    @(negedge clk);
    opSel = 2'(op); wordCount = 8'(wc); addrExt = 2'(ext);
    busAddr = 16'(ba); dblDensity = dbl;
    beatCnt = 0; validCnt = 0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      opSel = 2'd1; wordCount = 8'd1;
      startPulse = 1'b1;           // R10: ignored while busy
      @(negedge clk);
      startPulse = 1'b0;
    end
    for (int k = 0; k < 3000 && mPh != 0; k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic checkBuf(string tag);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      bufRdIdx = 8'(i);
      #1 chk(tag, bufRdData, mBuf[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 memReqValid", memReqValid, 0);
    chk("R1 donePulse", donePulse, 0);
    chk("R1 flags", {wcOverflow, nxmFlag}, 0);
    chk("R1 residualWc", residualWc, 0);
    checkBuf("R1 buffer");

    // R2 R4 fill across an address carry into the extension
    runOp(0, 5, 1, 16'hFFFD, 1, 0);
    chk("R2 beat count", beatCnt, 10);
    checkBuf("R4 buffer after fill");

    // R5 empty of the filled buffer
    runOp(1, 3, 2, 16'h0100, 1, 0);
    chk("R5 beat count", beatCnt, 6);

    // R3 single-density boundary accepted, one more overflows
    runOp(0, 64, 0, 16'h2000, 0, 0);
    chk("R3 boundary single beats", beatCnt, 128);
    chk("R3 boundary no overflow", wcOverflow, 0);
    runOp(0, 65, 0, 16'h3000, 0, 0);
    chk("R3 overflow no traffic", validCnt, 0);
    chk("R3 overflow flag", wcOverflow, 1);
    checkBuf("R3 buffer untouched");

    // R3 double-density boundary
    runOp(1, 129, 0, 16'h0, 1, 0);
    chk("R3 overflow double", wcOverflow, 1);
    runOp(1, 128, 3, 16'hFF80, 1, 0);
    chk("R3 double boundary beats", beatCnt, 256);

    // R8 zero word count: no traffic, fill still clears
    runOp(0, 0, 0, 16'h40, 1, 0);
    chk("R8 no traffic", validCnt, 0);
    checkBuf("R8 buffer cleared");

    // R6 status write ignores word count and density
    statusBytes = 64'hF1E2_D3C4_B5A6_9788;
    runOp(2, 200, 2, 16'h0500, 0, 0);
    chk("R6 beat count", beatCnt, 8);
    chk("R6 no overflow", wcOverflow, 0);
    statusBytes = 64'h0123_4567_89AB_CDEF;
    runOp(3, 0, 0, 16'h0600, 1, 0);
    chk("R6 alt code beats", beatCnt, 8);

    // R7 fault mid-fill: 8 bytes requested, fault on the 4th
    runOp(0, 7, 0, 16'h1000, 1, 0);
    faultOn = 1'b1; faultAddr = 18'h01103;
    runOp(0, 4, 0, 16'h1100, 1, 0);
    chk("R7 nxm set", nxmFlag, 1);
    chk("R7 residual", residualWc, 2);
    chk("R7 beats until fault", beatCnt, 4);
    checkBuf("R7 buffer after fault");
    faultOn = 1'b0;

    // R10 start while busy ignored
    runOp(0, 6, 0, 16'h7000, 0, 1);
    chk("R10 busy start ignored beats", beatCnt, 12);
    checkBuf("R10 buffer");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, failCnt);
    $finish;
  end

endmodule